// File: doc/BRIEF.md
# Randomized-Address Accumulate Sequencer

This block executes one compressed-sensing accumulation per command. A command carries a buffer base address and a 16-bit sample. The unit then performs a configured number of read-add-write repetitions. Each repetition adds the sample to the buffer word at the base plus a pseudo-random offset. The offset is taken from an internal LFSR that advances several steps between repetitions, so successive offsets are weakly correlated. One repetition is issued per clock cycle.

The memory has a synchronous read port and a separate write port. The read-add-write is split over two cycles. When two back-to-back repetitions land on the same word, the value still being written is forwarded to the adder, so repeated offsets accumulate every time.

The command input uses valid/ready. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low for the whole operation, and `cmd_valid` may be held high until it is taken. Neither memory port has back-pressure: a read returns data one cycle after it is issued, and a write commits at the clock edge that closes its cycle. The configuration pins and `busy`/`done` are plain level or strobe signals.

Top module: `csa_accum_seq`

## Requirements
- R1: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high exactly when the unit is idle. A `cmd_valid` seen while busy is ignored: no extra repetitions, writes or `done` result from it.
- R2: Each repetition reads the word at address (base + offset) mod 2^16. In the following cycle it writes the same address with (old word + sample) mod 2^16, with no saturation.
- R3: The offset is the low N bits of the LFSR state present when the repetition is issued. N is `cfg_idx_bits`, which ranges over 0..16, and N = 0 always gives offset 0.
- R4: One LFSR step puts the XOR of all bits of (state AND `cfg_poly`) into bit 15 and shifts the other bits right by one. After each repetition the LFSR advances N steps. The state persists across commands. The LFSR resets to 16'hACE1.
- R5: A command performs exactly `cfg_reps` repetitions, one read per cycle on consecutive cycles. A count of 0 performs no memory access.
- R6: When the same offset appears more than once within a command, including on consecutive repetitions, the sample is added once for every appearance.
- R7: Take the accepting clock edge as edge 0. For a count I > 0, `done` goes high at edge I+1, which is the edge that commits the final write. For I = 0 it goes high at edge 0. Either way it stays high for one cycle.
- R8: After reset the unit is idle: `cmd_ready` = 1, and `busy`, `done`, `rd_en` and `wr_en` are all 0.
- R9: Base, sample, polynomial, index width and count are captured at acceptance. Changing those inputs while busy has no effect on the running command.
- R10: A `cfg_seed_load` pulse loads `cfg_seed` into the LFSR only while idle. A pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_poly | input | 16 | LFSR feedback tap mask |
| cfg_seed | input | 16 | LFSR load value |
| cfg_seed_load | input | 1 | Load strobe for the LFSR, honoured only while idle |
| cfg_idx_bits | input | 5 | Offset width N, 0..16 |
| cfg_reps | input | 5 | Repetitions per command |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| cmd_base | input | 16 | Buffer base address |
| cmd_sample | input | 16 | Sample to accumulate |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | 16 | Memory read address |
| rd_data | input | 16 | Read data, one cycle after the request |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 16 | Memory write address |
| wr_data | output | 16 | Memory write data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after back-to-back hits on the same word. With an offset width of 0 or 1, nearly every repetition re-hits the word just written, and a design without forwarding would lose all but one of those additions. Samples near 0x8000 and 0xFFF0 exercise wraparound: a saturating adder would leave the buffer short. Counts of 0 and 31, and a base near the top of the address space, check the repetition counter and the address wrap. Commands, seed loads and configuration changes presented while busy check that a running command is not disturbed: a design that accepted any of them would produce extra writes or a different address sequence.

// File: rtl/csa_pkg.sv
package csa_pkg;
  localparam int unsigned LFSR_W = 16;
  localparam int unsigned NB_W   = $clog2(LFSR_W + 1);

  // one LFSR step: parity of tapped bits enters at the top, state shifts right
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s,
                                                  input logic [LFSR_W-1:0] p);
    return {^(s & p), s[LFSR_W-1:1]};
  endfunction
endpackage

// File: rtl/csa_lfsr_idx.sv
module csa_lfsr_idx
  import csa_pkg::*;
#(
  parameter logic [LFSR_W-1:0] RST_STATE = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LFSR_W-1:0] seed,
  input  logic              adv,
  input  logic [LFSR_W-1:0] poly,
  input  logic [NB_W-1:0]   nbits,
  output logic [LFSR_W-1:0] idx
);
  logic [LFSR_W-1:0] st;
  logic [LFSR_W-1:0] chain [LFSR_W+1];
  logic [LFSR_W-1:0] mask;

  assign chain[0] = st;

  // unrolled multi-step advance: stage j is active when j < nbits
  generate
    for (genvar j = 0; j < LFSR_W; j++) begin : g_step
      assign chain[j+1] = (NB_W'(j) < nbits) ? lfsr_step(chain[j], poly) : chain[j];
    end
  endgenerate

  assign mask = ~({LFSR_W{1'b1}} << nbits);
  assign idx  = st & mask;

  always_ff @(posedge clk) begin
    if (!rst_n)    st <= RST_STATE;
    else if (load) st <= seed;
    else if (adv)  st <= chain[LFSR_W];
  end
endmodule

// File: rtl/csa_issue_ctrl.sv
module csa_issue_ctrl
  import csa_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned REP_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [DATA_W-1:0] cmd_sample,
  input  logic [LFSR_W-1:0] cfg_poly,
  input  logic [NB_W-1:0]   cfg_idx_bits,
  input  logic [REP_W-1:0]  cfg_reps,
  output logic              iss_active,
  output logic              iss_last,
  output logic [ADDR_W-1:0] base_q,
  output logic [DATA_W-1:0] samp_q,
  output logic [LFSR_W-1:0] poly_q,
  output logic [NB_W-1:0]   nbits_q,
  output logic              zero_done
);
  logic [REP_W-1:0] rem;

  assign iss_last = iss_active && (rem == REP_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iss_active <= 1'b0;
      rem        <= '0;
      base_q     <= '0;
      samp_q     <= '0;
      poly_q     <= '0;
      nbits_q    <= '0;
      zero_done  <= 1'b0;
    end else if (accept) begin
      base_q     <= cmd_base;
      samp_q     <= cmd_sample;
      poly_q     <= cfg_poly;
      nbits_q    <= cfg_idx_bits;
      rem        <= cfg_reps;
      iss_active <= (cfg_reps != '0);
      zero_done  <= (cfg_reps == '0);
    end else begin
      zero_done <= 1'b0;
      if (iss_active) begin
        rem <= rem - REP_W'(1);
        if (iss_last) iss_active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/csa_rmw_pipe.sv
module csa_rmw_pipe #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic              issue_last,
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              s1_valid,
  output logic              s1_done
);
  logic [ADDR_W-1:0] s1_addr;
  logic              s1_last;
  logic              fwd_hit;
  logic [DATA_W-1:0] fwd_val;
  logic [DATA_W-1:0] operand;

  assign rd_en   = issue;
  assign rd_addr = issue_addr;

  // a read issued alongside a write to the same word sees stale data: bypass it
  assign operand = fwd_hit ? fwd_val : rd_data;
  assign wr_en   = s1_valid;
  assign wr_addr = s1_addr;
  assign wr_data = operand + sample;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_addr  <= '0;
      s1_last  <= 1'b0;
      fwd_hit  <= 1'b0;
      fwd_val  <= '0;
      s1_done  <= 1'b0;
    end else begin
      s1_valid <= issue;
      s1_addr  <= issue_addr;
      s1_last  <= issue && issue_last;
      fwd_hit  <= s1_valid && issue && (issue_addr == s1_addr);
      fwd_val  <= wr_data;
      s1_done  <= s1_valid && s1_last;
    end
  end
endmodule

// File: rtl/csa_accum_seq.sv
module csa_accum_seq
  import csa_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned REP_W  = 5,
  parameter logic [LFSR_W-1:0] SEED_RST = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LFSR_W-1:0] cfg_poly,
  input  logic [LFSR_W-1:0] cfg_seed,
  input  logic              cfg_seed_load,
  input  logic [NB_W-1:0]   cfg_idx_bits,
  input  logic [REP_W-1:0]  cfg_reps,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [DATA_W-1:0] cmd_sample,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done
);
  logic              accept;
  logic              iss_active, iss_last, zero_done;
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] samp_q;
  logic [LFSR_W-1:0] poly_q;
  logic [NB_W-1:0]   nbits_q;
  logic [LFSR_W-1:0] idx;
  logic              s1_valid, s1_done;

  assign busy      = iss_active || s1_valid;
  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign done      = s1_done || zero_done;

  csa_issue_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REP_W(REP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .cmd_base(cmd_base), .cmd_sample(cmd_sample),
    .cfg_poly(cfg_poly), .cfg_idx_bits(cfg_idx_bits), .cfg_reps(cfg_reps),
    .iss_active(iss_active), .iss_last(iss_last),
    .base_q(base_q), .samp_q(samp_q), .poly_q(poly_q), .nbits_q(nbits_q),
    .zero_done(zero_done)
  );

  csa_lfsr_idx #(.RST_STATE(SEED_RST)) u_lfsr (
    .clk(clk), .rst_n(rst_n),
    .load(cfg_seed_load && !busy), .seed(cfg_seed),
    .adv(iss_active), .poly(poly_q), .nbits(nbits_q),
    .idx(idx)
  );

  csa_rmw_pipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .issue(iss_active), .issue_addr(base_q + ADDR_W'(idx)), .issue_last(iss_last),
    .sample(samp_q), .rd_data(rd_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .s1_valid(s1_valid), .s1_done(s1_done)
  );
endmodule

// File: rtl/csa_accum_seq_chk.sv
module csa_accum_seq_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned REP_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [REP_W-1:0]  cfg_reps,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              busy,
  input logic              done
);
  assert_wr_follows_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(rd_en));

  assert_wr_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr == $past(rd_addr)));

  assert_rd_when_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy);

  assert_accept_starts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (busy || done));

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(wr_en) || $past(cmd_valid && cmd_ready && (cfg_reps == '0))));

  assert_idle_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_en);
endmodule

bind csa_accum_seq csa_accum_seq_chk #(.ADDR_W(ADDR_W), .REP_W(REP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cfg_reps(cfg_reps), .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en),
  .wr_addr(wr_addr), .busy(busy), .done(done)
);

// File: tb/csa_accum_seq_tb.sv
module csa_accum_seq_tb;
  localparam int MEMW = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_poly = 16'hB400;
  logic [15:0] cfg_seed = 16'h0;
  logic        cfg_seed_load = 1'b0;
  logic [4:0]  cfg_idx_bits = 5'd8;
  logic [4:0]  cfg_reps = 5'd12;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_base = 16'h0;
  logic [15:0] cmd_sample = 16'h0;
  logic        rd_en, wr_en, busy, done;
  logic [15:0] rd_addr, wr_addr, wr_data;
  logic [15:0] rd_data;

  logic [15:0] mem [MEMW];
  logic [15:0] mm  [MEMW];
  logic [15:0] mst = 16'hACE1;
  int          wr_count = 0;
  int          checks = 0;
  int          fails = 0;

  always #2.5 clk = ~clk;

  csa_accum_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_poly(cfg_poly), .cfg_seed(cfg_seed),
    .cfg_seed_load(cfg_seed_load), .cfg_idx_bits(cfg_idx_bits), .cfg_reps(cfg_reps),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_base(cmd_base),
    .cmd_sample(cmd_sample), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(done)
  );

  // memory: synchronous read returning old data on a same-edge write
  always @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr[9:0]];
    if (wr_en) begin
      mem[wr_addr[9:0]] <= wr_data;
      wr_count <= wr_count + 1;
    end
  end

  // fields: base[41:26] sample[25:10] idx_bits[9:5] reps[4:0]
  localparam logic [41:0] VEC [6] = '{
    {16'h0100, 16'h0011, 5'd8, 5'd12},
    {16'h0100, 16'hFFF0, 5'd8, 5'd12},
    {16'h0000, 16'h7FFF, 5'd8, 5'd12},
    {16'h0200, 16'h0003, 5'd1, 5'd12},
    {16'h0300, 16'h0101, 5'd4, 5'd7},
    {16'h0120, 16'h8001, 5'd8, 5'd31}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mstep(input logic [15:0] s, input logic [15:0] p);
    return {^(s & p), s[15:1]};
  endfunction

  task automatic model(input logic [15:0] b, input logic [15:0] s,
                       input int nb, input int r, input logic [15:0] p);
    logic [15:0] m;
    logic [15:0] a;
    m = (nb >= 16) ? 16'hFFFF : 16'((32'd1 << nb) - 1);
    for (int i = 0; i < r; i++) begin
      a = b + (mst & m);
      mm[a[9:0]] = mm[a[9:0]] + s;
      for (int k = 0; k < nb; k++) mst = mstep(mst, p);
    end
  endtask

  task automatic launch(input logic [15:0] b, input logic [15:0] s,
                        input logic [4:0] nb, input logic [4:0] r);
    @(negedge clk);
    cmd_base = b; cmd_sample = s; cfg_idx_bits = nb; cfg_reps = r; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 200) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic cmp_mem(input string req);
    int bad;
    int first;
    bad = 0; first = -1;
    for (int i = 0; i < MEMW; i++)
      if (mem[i] !== mm[i]) begin
        if (first < 0) first = i;
        bad++;
      end
    chk(bad == 0, req, $sformatf("buffer mismatches (first at %0d)", first), bad, 0);
  endtask

  // full command: latency (R7), write count (R5), pulse width (R7), buffer (R2/R3/R4/R6)
  task automatic run(input logic [15:0] b, input logic [15:0] s,
                     input logic [4:0] nb, input logic [4:0] r, input string req);
    int n;
    int w0;
    w0 = wr_count;
    model(b, s, int'(nb), int'(r), cfg_poly);
    launch(b, s, nb, r);
    wait_done(n);
    chk(n == ((r == 0) ? 0 : int'(r) + 1), "R7", "done latency", n,
        (r == 0) ? 0 : int'(r) + 1);
    chk(wr_count - w0 == int'(r), "R5", "writes per command", wr_count - w0, int'(r));
    @(negedge clk);
    chk(done == 1'b0, "R7", "done one cycle wide", int'(done), 0);
    cmp_mem(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    int w0;
    for (int i = 0; i < MEMW; i++) begin
      mem[i] = 16'(i * 37) ^ 16'h5A5A;
      mm[i]  = 16'(i * 37) ^ 16'h5A5A;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: idle after reset
    chk(cmd_ready && !busy && !done && !rd_en && !wr_en, "R8", "reset idle state",
        {cmd_ready, busy, done, rd_en, wr_en}, 5'b10000);

    // table: R2 R3 R4 (reset seed, persistence) R6 (1-bit offsets) wrap via samples
    for (int v = 0; v < 6; v++)
      run(VEC[v][41:26], VEC[v][25:10], VEC[v][9:5], VEC[v][4:0], "R2_R3_R4_R6");

    // R10: seed load while idle, then R6 with offset width 0 (every hit consecutive)
    @(negedge clk);
    cfg_seed = 16'h1D2C; cfg_seed_load = 1'b1;
    @(negedge clk);
    cfg_seed_load = 1'b0;
    mst = 16'h1D2C;
    run(16'h03F0, 16'h1111, 5'd0, 5'd12, "R6");
    run(16'h0040, 16'h0005, 5'd8, 5'd12, "R10");

    // R5: zero repetitions, no access
    run(16'h0080, 16'h4444, 5'd8, 5'd0, "R5");

    // R2: address wraps past the top of the space; full 16-bit offsets
    run(16'hFFF8, 16'h0123, 5'd8, 5'd12, "R2");
    run(16'h0000, 16'h0007, 5'd16, 5'd5, "R3");

    // R1, R9, R10: command, config and seed load presented while busy
    w0 = wr_count;
    model(16'h0100, 16'h0202, 8, 12, cfg_poly);
    launch(16'h0100, 16'h0202, 5'd8, 5'd12);
    cmd_valid = 1'b1; cmd_base = 16'h0200; cmd_sample = 16'h7777;
    cfg_idx_bits = 5'd3; cfg_reps = 5'd2; cfg_poly = 16'hFFFF;
    cfg_seed = 16'h0001; cfg_seed_load = 1'b1;
    @(negedge clk);
    cfg_seed_load = 1'b0;
    chk(cmd_ready == 1'b0, "R1", "ready low while busy", int'(cmd_ready), 0);
    repeat (2) @(negedge clk);
    cmd_valid = 1'b0;
    wait_done(n);
    chk(n == 10, "R9", "done latency with changed config", n, 10);
    chk(wr_count - w0 == 12, "R1", "writes ignoring busy command", wr_count - w0, 12);
    @(negedge clk);
    chk(!done && !busy, "R1", "no second command", {done, busy}, 0);
    cmp_mem("R9_R10");
    cfg_poly = 16'hB400;
    run(16'h0180, 16'h0009, 5'd8, 5'd12, "R10");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule